// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the slave end of a two-wire serial bus (SCL clock, SDA open-drain data). It lets a bus master reach a bank of 8-bit registers that sits outside the block. The block holds one internal pointer that selects the register. Both bus lines are oversampled by a system clock that runs at least eight times faster than SCL. SDA is driven only through a pull-down enable, and the pad or board pull-up provides the high level.

A transaction starts with a START condition and then a 7-bit address byte. The address is 0101 1 followed by the two strap bits. The eighth bit of that byte fixes the direction until the next START. In a write, the first data byte always repositions the pointer. A second byte is written into the register that the pointer selects, and any later bytes are acknowledged and dropped. In a read, the block returns the register at the current pointer, so a master whose pointer is already correct skips the pointer write.

The register side is a plain synchronous port. A write strobe comes with the address and data. A read strobe expects the data one system clock later.

Top module: `twr_reg_slave`

## Requirements
- R1: The block acknowledges (holds SDA low through the ninth SCL pulse) only an address byte whose upper seven bits equal {0101 1, addr_sel_i[1], addr_sel_i[0]}. On any other address it never pulls SDA low until a new START.
- R2: In a write (address-byte bit 0 = 0), the first data byte is acknowledged and loads the pointer, and the pointer appears on reg_addr_o. A write that stops after this byte changes no register.
- R3: The second data byte of a write is acknowledged and causes exactly one reg_we_o pulse of one clock cycle, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R4: In a read (address-byte bit 0 = 1), the block sends, MSB first, the byte that the register port returns for the current pointer. No earlier pointer write is needed.
- R5: During a read, a master acknowledge (SDA low on the ninth pulse) makes the block resend the register at the same, unchanged pointer. A no-acknowledge (SDA high) makes it release SDA for the rest of the transaction.
- R6: Write data bytes after the second are acknowledged, but they change neither the pointer nor any register.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle. A START (SDA falling while SCL is high) restarts address reception from any state, so a repeated START between a pointer write and a read works.
- R8: The block starts pulling SDA low only while SCL is low.
- R9: After reset, SDA is released, no strobe is active, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 2 | Static strap bits, low two bits of the bus address |
| reg_addr_o | output | ADDR_W | Pointer, register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe, data expected next cycle |
| reg_rdata_i | input | 8 | Register read data |

## Verification
Random transactions mix pointer-only writes, pointer-plus-data writes, writes with surplus bytes, single and repeated reads, and frames to foreign addresses. A bench model of the pointer and register contents predicts every returned byte. This separates a stale or auto-incremented pointer from a correct one, and a dropped write from a misplaced one. Directed cases cover a repeated START between pointer write and read, a START that breaks into a half-sent byte, and a no-acknowledge followed by extra clocking to show that SDA is released.

// File: rtl/twr_pkg.sv
// Shared types for the two-wire register slave.
// Assumes: byte-oriented bus, 8-bit registers.
package twr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } twr_state_e;
endpackage

// File: rtl/twr_line_sync.sv
// Multi-flop synchronizer for one asynchronous bus line.
// Assumes STAGES >= 2; resets to the idle (high) bus level.
module twr_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twr_bus_events.sv
// Turns synchronized SCL/SDA levels into edge and START/STOP events.
// Assumes both inputs pass through synchronizers of the same depth.
module twr_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    // Remember the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode the events from the old and new levels.
    always_comb begin
        scl_o      = scl_i;
        sda_o      = sda_i;
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/twr_reg_slave.sv
// Two-wire bus slave that reaches a register bank through a pointer.
// Assumes clk is at least 8x SCL and the register port returns read
// data one clk after reg_re_o. No clock stretching.
module twr_reg_slave #(
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_ADDR_HI = 5'b01011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_pd_o,
    input  logic [1:0]               addr_sel_i,
    output logic [ADDR_W-1:0]        reg_addr_o,
    output logic [twr_pkg::BYTE_W-1:0] reg_wdata_o,
    output logic                     reg_we_o,
    output logic                     reg_re_o,
    input  logic [twr_pkg::BYTE_W-1:0] reg_rdata_i
);
    import twr_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    logic [1:0] raw_lines, sync_lines;
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    twr_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  shreg_q, tx_q, wdata_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [1:0]         byte_idx_q;
    logic               rw_q, pd_q, we_q, re_q;
    logic [6:0]         own_addr;

    assign raw_lines = {sda_i, scl_i};
    assign own_addr  = {DEV_ADDR_HI, addr_sel_i};

    // One synchronizer per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        twr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_lines[g]),
            .q_o   (sync_lines[g])
        );
    end

    twr_bus_events u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (sync_lines[0]),
        .sda_i      (sync_lines[1]),
        .scl_o      (scl_lvl),
        .sda_o      (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    // Transaction sequencer: shifts bits, acks, loads pointer, moves data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            tx_q       <= '0;
            wdata_q    <= '0;
            ptr_q      <= '0;
            byte_idx_q <= '0;
            rw_q       <= 1'b0;
            pd_q       <= 1'b0;
            we_q       <= 1'b0;
            re_q       <= 1'b0;
        end else begin
            we_q <= 1'b0;
            re_q <= 1'b0;
            if (start_evt) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                pd_q    <= 1'b0;
            end else if (stop_evt) begin
                state_q <= ST_IDLE;
                pd_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            if (shreg_q[BYTE_W-1:1] == own_addr) begin
                                pd_q       <= 1'b1;
                                rw_q       <= shreg_q[0];
                                re_q       <= shreg_q[0];
                                byte_idx_q <= '0;
                                state_q    <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q    <= reg_rdata_i;
                                pd_q    <= ~reg_rdata_i[BYTE_W-1];
                                state_q <= ST_RD_BYTE;
                            end else begin
                                pd_q    <= 1'b0;
                                state_q <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            pd_q    <= 1'b1;
                            state_q <= ST_WR_ACK;
                            if (byte_idx_q == 2'd0) begin
                                ptr_q <= shreg_q[ADDR_W-1:0];
                            end else if (byte_idx_q == 2'd1) begin
                                wdata_q <= shreg_q;
                                we_q    <= 1'b1;
                            end
                            if (byte_idx_q != 2'd2) byte_idx_q <= byte_idx_q + 1'b1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            pd_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt_q == CNT_FULL) begin
                                pd_q    <= 1'b0;
                                re_q    <= 1'b1;
                                state_q <= ST_RD_ACK;
                            end else begin
                                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                                pd_q <= ~tx_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                        end else if (scl_fall) begin
                            if (!shreg_q[0]) begin
                                tx_q    <= reg_rdata_i;
                                pd_q    <= ~reg_rdata_i[BYTE_W-1];
                                cnt_q   <= '0;
                                state_q <= ST_RD_BYTE;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_pd_o    = pd_q;
    assign reg_addr_o  = ptr_q;
    assign reg_wdata_o = wdata_q;
    assign reg_we_o    = we_q;
    assign reg_re_o    = re_q;
endmodule

// File: rtl/twr_reg_slave_chk.sv
// Property checker for twr_reg_slave, attached with bind.
// Assumes it sees the synchronized SCL level and the decoded bus events.
module twr_reg_slave_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_lvl,
    input logic               start_evt,
    input logic               stop_evt,
    input logic               sda_pd,
    input logic               we,
    input logic               re,
    input twr_pkg::twr_state_e state
);
    import twr_pkg::*;

    AST_PD_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> !scl_lvl); // R8
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we); // R3
    AST_WE_RE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re)); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pd); // R1
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state == ST_IDLE)); // R7
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR)); // R7
    AST_RE_IN_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        re |-> (state == ST_ADDR_ACK || state == ST_RD_ACK)); // R4
endmodule

bind twr_reg_slave twr_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_pd    (pd_q),
    .we        (we_q),
    .re        (re_q),
    .state     (state_q)
);

// File: tb/sim_twr_reg_slave.sv
module sim_twr_reg_slave;
    localparam int Q = 5;                 // sysclk per quarter SCL period
    localparam logic [1:0] SEL = 2'b10;
    localparam logic [6:0] DEV = {5'b01011, SEL};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic [7:0] bank [256];
    int         we_count = 0;
    int         n_checks = 0;
    int         n_fails = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;

    always #2 clk = ~clk;                  // 250 MHz

    assign sda_line = sda_m & ~sda_pd;

    twr_reg_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pd_o    (sda_pd),
        .addr_sel_i  (SEL),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_re_o    (reg_re),
        .reg_rdata_i (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // Register bank behind the port: synchronous write and read.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bank[i] <= init_val(i);
            reg_rdata <= '0;
        end else begin
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                we_count <= we_count + 1;
            end
            if (reg_re) reg_rdata <= bank[reg_addr];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic tx_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        tx_bits(b, 8);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic rx_byte(output logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
        end
        sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    // Write: pointer byte plus ndata (0..2) data bytes.
    task automatic txn_write(input logic [7:0] p, input int ndata,
                             input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        int   we0;
        we0 = we_count;
        bus_start();
        tx_byte({DEV, 1'b0}, ack); check("R1 addr ack (write)", ack, 1);
        tx_byte(p, ack);           check("R2 pointer byte ack", ack, 1);
        if (ndata >= 1) begin tx_byte(d1, ack); check("R3 data byte ack", ack, 1); end
        if (ndata >= 2) begin tx_byte(d2, ack); check("R6 surplus byte ack", ack, 1); end
        bus_stop();
        exp_ptr = p;
        if (ndata >= 1) exp_mem[p] = d1;
        check("R2 pointer on reg_addr_o", reg_addr, p);
        check("R3 write strobe count", we_count - we0, (ndata >= 1) ? 1 : 0);
    endtask

    // Read: nbytes from the current pointer; master acks all but last.
    task automatic txn_read(input int nbytes);
        logic       ack;
        logic [7:0] b;
        bus_start();
        tx_byte({DEV, 1'b1}, ack); check("R1 addr ack (read)", ack, 1);
        for (int k = 0; k < nbytes; k++) begin
            rx_byte(b, (k == nbytes - 1));
            if (k == 0) check("R4 read byte at pointer", b, exp_mem[exp_ptr]);
            else        check("R5 repeat read, same pointer", b, exp_mem[exp_ptr]);
        end
        bus_stop();
    endtask

    // Frame to a foreign address: must never be acknowledged.
    task automatic txn_foreign(input logic [6:0] a, input logic [7:0] d);
        logic ack;
        int   we0;
        we0 = we_count;
        bus_start();
        tx_byte({a, 1'b0}, ack); check("R1 foreign addr no ack", ack, 0);
        tx_byte(d, ack);         check("R1 foreign data no ack", ack, 0);
        bus_stop();
        check("R1 foreign no write", we_count - we0, 0);
        check("R1 foreign pointer kept", reg_addr, exp_ptr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic [7:0] b;
        logic [6:0] fa;
        int         kind;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        exp_ptr = 8'h00;
        repeat (4) @(negedge clk);
        check("R9 reset sda released", sda_pd, 0);
        check("R9 reset no write strobe", reg_we, 0);
        check("R9 reset pointer zero", reg_addr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 idle after reset", sda_pd, 0);

        // R4: read without a prior pointer write (pointer 0)
        txn_read(1);
        // R2: pointer-only write, then read
        txn_write(8'h3C, 0, 8'h00, 8'h00);
        txn_read(1);
        // R3: pointer + data, read back; R5: ack keeps pointer
        txn_write(8'h81, 1, 8'hA5, 8'h00);
        txn_read(3);
        // R6: surplus byte dropped
        txn_write(8'h82, 2, 8'h12, 8'hEE);
        check("R6 pointer not advanced", reg_addr, 8'h82);
        txn_read(1);
        exp_ptr = 8'h83;
        txn_write(8'h83, 0, 8'h00, 8'h00);
        txn_read(1);
        check("R6 next register untouched", exp_mem[8'h83], init_val(8'h83));

        // R7: repeated START between pointer write and read
        bus_start();
        tx_byte({DEV, 1'b0}, ack); check("R7 Sr addr ack", ack, 1);
        tx_byte(8'h81, ack);       check("R7 Sr pointer ack", ack, 1);
        exp_ptr = 8'h81;
        bus_start();
        tx_byte({DEV, 1'b1}, ack); check("R7 Sr read addr ack", ack, 1);
        rx_byte(b, 1'b1);          check("R7 Sr read data", b, exp_mem[8'h81]);
        bus_stop();

        // R7: START cutting into a half-sent byte
        bus_start();
        tx_bits({DEV, 1'b0}, 3);
        bus_start();
        tx_byte({DEV, 1'b1}, ack); check("R7 restart mid-byte ack", ack, 1);
        rx_byte(b, 1'b1);          check("R7 restart mid-byte data", b, exp_mem[exp_ptr]);
        bus_stop();

        // R5: NACK releases SDA; zero byte makes a drive visible
        txn_write(8'h10, 1, 8'h00, 8'h00);
        bus_start();
        tx_byte({DEV, 1'b1}, ack); check("R5 nack test addr ack", ack, 1);
        rx_byte(b, 1'b1);          check("R4 zero byte read", b, 8'h00);
        rx_byte(b, 1'b1);          check("R5 SDA released after nack", b, 8'hFF);
        bus_stop();

        // R1: neighbour addresses differing in strap bits and upper bits
        txn_foreign({5'b01011, ~SEL}, 8'h55);
        txn_foreign({5'b11011, SEL}, 8'h00);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            kind = int'($urandom_range(0, 4));
            case (kind)
                0: txn_write(8'($urandom), 0, 8'h00, 8'h00);
                1: txn_write(8'($urandom), 1, 8'($urandom), 8'h00);
                2: txn_write(8'($urandom), 2, 8'($urandom), 8'($urandom));
                3: txn_read(int'($urandom_range(1, 3)));
                default: begin
                    fa = 7'($urandom);
                    if (fa == DEV) fa = fa ^ 7'h01;
                    txn_foreign(fa, 8'($urandom));
                end
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule